// File: doc/BRIEF.md
# Framed Serial-to-Byte Capture Interface

This block sits behind a converter whose serial port is the clock master. The converter drives a serial clock, a data line and a one-clock frame-start pulse. The block shifts the data in and counts clocks within each 16-bit word. It places every completed byte into a holding register, where a slow host can read it at leisure. A single handshake line changes level each time a new byte lands. The host watches for either edge on that line and then reads the holding register.

A frame has six 16-bit word slots, 96 serial clocks in all. Each word is a two's complement sample sent most significant bit first, so its high byte arrives first. Only slots 0 and 1 carry data, in the order voltage then current; the data line is undefined in the remaining four slots. Alongside the byte, the block reports whether it is the high or the low half, which slot it came from and whether that slot holds valid data. Once all six slots are delivered, the block goes quiet until the next frame-start pulse. A sticky overrun flag records a byte that was replaced before the host acknowledged it.

Top module: `frame_byte_capture`

## Requirements
- R1: An active-low asynchronous reset clears the holding register, the handshake line, the byte index, the slot index, the valid qualifier and the overrun flag to 0, and leaves the block waiting for a frame-start pulse.
- R2: The frame-start pulse is sampled on a rising serial clock edge and carries no data bit. The next 8 rising edges shift in a byte, first bit in the MSB (bit 7), and that byte appears in the holding register right after the 8th edge.
- R3: The handshake line goes to 1 on the 8th clock of each word and back to 0 on the 16th, so it changes level exactly once per latched byte.
- R4: The byte index output is 1 when the latched byte is the first (high) byte of its word, and 0 when it is the second (low) byte.
- R5: The slot index output gives the word slot, 0 to 5, of the latched byte, counted from the frame-start pulse.
- R6: The valid qualifier is 1 only while the latched byte comes from slot 0 or slot 1.
- R7: After the 96th clock of a frame, further clocks neither latch a byte nor move the handshake line until the next frame-start pulse. The same holds after reset, before the first pulse.
- R8: A frame-start pulse in the middle of a frame discards the partial byte, drives the handshake line to 0 and restarts word and slot counting. It leaves the holding register unchanged.
- R9: A pending flag sets on every latch and clears on a clock with the acknowledge input high. If a latch happens while the flag is set and acknowledge is low, the overrun output goes to 1 and stays there until reset.
- R10: The holding register and its qualifiers keep their values between latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the converter; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame-start pulse, synchronous to sclk |
| sdata | input | 1 | Serial data, MSB first |
| host_ack | input | 1 | Host acknowledge of the byte it has read |
| byte_out | output | 8 | Holding register |
| ready_tgl | output | 1 | Handshake line; either edge marks a new byte |
| byte_hi | output | 1 | 1 for the high byte of a word, 0 for the low byte |
| slot_idx | output | 3 | Word slot of the held byte |
| byte_valid | output | 1 | Held byte is from a data-carrying slot |
| overrun | output | 1 | Sticky flag for a byte replaced before it was acknowledged |

## Verification
A counter off by one shows up within 8 clocks: the handshake edge lands on the wrong clock, or the held byte comes out rotated by one bit. A slot counter that drifts, or that fails to stop, gives a wrong slot index or valid flag on the next latch. It can also give handshake edges during the idle gap after the 96th clock. A frame-start pulse that clears too little leaves a rotated first byte in the next frame. One that clears too much corrupts the holding register. Sweeping several whole frames with different data patterns, including a restart in mid-frame and a frame with no acknowledges, exposes each of these faults within a single frame.

// File: rtl/frame_byte_capture.sv
module frame_byte_capture #(
  parameter int BYTE_W      = 8,
  parameter int SLOTS       = 6,
  parameter int VALID_SLOTS = 2,
  parameter bit OVR_EN      = 1'b1
) (
  input  logic                              sclk,
  input  logic                              rst_n,
  input  logic                              fsync,
  input  logic                              sdata,
  input  logic                              host_ack,
  output logic [BYTE_W-1:0]                 byte_out,
  output logic                              ready_tgl,
  output logic                              byte_hi,
  output logic [$clog2(SLOTS+1)-1:0]        slot_idx,
  output logic                              byte_valid,
  output logic                              overrun
);

  localparam int CNT_W  = $clog2(2*BYTE_W);
  localparam int SLOT_W = $clog2(SLOTS+1);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] slot_cur;
  logic              done;

  wire [BYTE_W-1:0] sh_next  = {shreg[BYTE_W-2:0], sdata};
  wire              last_bit = (cnt[CNT_W-2:0] == '1);
  wire              word_end = (cnt == '1);
  wire              latch    = !fsync && !done && last_bit;

  assign ready_tgl = cnt[CNT_W-1];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      cnt      <= '0;
      slot_cur <= '0;
      done     <= 1'b1;
    end else if (fsync) begin
      shreg    <= '0;
      cnt      <= '0;
      slot_cur <= '0;
      done     <= 1'b0;
    end else if (!done) begin
      shreg <= sh_next;
      cnt   <= cnt + 1'b1;
      if (word_end) begin
        if (slot_cur == SLOT_W'(SLOTS-1)) done <= 1'b1;
        else                              slot_cur <= slot_cur + 1'b1;
      end
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      byte_out   <= '0;
      byte_hi    <= 1'b0;
      slot_idx   <= '0;
      byte_valid <= 1'b0;
    end else if (latch) begin
      byte_out   <= sh_next;
      byte_hi    <= !cnt[CNT_W-1];
      slot_idx   <= slot_cur;
      byte_valid <= (slot_cur < SLOT_W'(VALID_SLOTS));
    end
  end

  generate
    if (OVR_EN) begin : g_ovr
      logic pend;
      logic ovr_q;
      always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
          pend  <= 1'b0;
          ovr_q <= 1'b0;
        end else if (latch) begin
          pend <= 1'b1;
          if (pend && !host_ack) ovr_q <= 1'b1;
        end else if (host_ack) begin
          pend <= 1'b0;
        end
      end
      assign overrun = ovr_q;
    end else begin : g_no_ovr
      assign overrun = 1'b0;
    end
  endgenerate

  AST_HS_MATCHES_INDEX: assert property (@(posedge sclk) disable iff (!rst_n)
    (ready_tgl != $past(ready_tgl)) && !$past(fsync) |-> byte_hi == ready_tgl); // R4

  AST_SLOT_IN_RANGE: assert property (@(posedge sclk) disable iff (!rst_n)
    slot_idx < SLOT_W'(SLOTS)); // R5

  AST_VALID_SLOT: assert property (@(posedge sclk) disable iff (!rst_n)
    byte_valid |-> slot_idx < SLOT_W'(VALID_SLOTS)); // R6

  AST_IDLE_QUIET: assert property (@(posedge sclk) disable iff (!rst_n)
    done && !fsync |=> $stable(ready_tgl) && $stable(byte_out)); // R7

  AST_FSYNC_CLEARS: assert property (@(posedge sclk) disable iff (!rst_n)
    fsync |=> !ready_tgl && $stable(byte_out)); // R8

  AST_OVR_STICKY: assert property (@(posedge sclk) disable iff (!rst_n)
    $past(overrun) |-> overrun); // R9

  AST_HOLD_STABLE: assert property (@(posedge sclk) disable iff (!rst_n)
    !latch |=> $stable(byte_out) && $stable(slot_idx) && $stable(byte_hi)); // R10

endmodule

// File: tb/frame_byte_capture_bench.sv
module frame_byte_capture_bench;
  localparam int PERIOD = 10;

  logic sclk = 1'b0, rst_n = 1'b0, fsync = 1'b0, sdata = 1'b0, host_ack = 1'b0;
  logic [7:0] byte_out;
  logic       ready_tgl, byte_hi, byte_valid, overrun;
  logic [2:0] slot_idx;

  frame_byte_capture u_frame_byte_capture (
    .sclk(sclk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata), .host_ack(host_ack),
    .byte_out(byte_out), .ready_tgl(ready_tgl), .byte_hi(byte_hi),
    .slot_idx(slot_idx), .byte_valid(byte_valid), .overrun(overrun)
  );

  always #(PERIOD/2) sclk = ~sclk;

  int checks = 0, fails = 0;
  logic pend_m = 1'b0, ovr_m = 1'b0;
  logic [7:0] last_byte = 8'h00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic d, input logic fs, input logic ack);
    sdata = d; fsync = fs; host_ack = ack;
    @(posedge sclk);
    @(negedge sclk);
  endtask

  function automatic logic [15:0] word_of(input int f, input int s);
    if (f == 0) return s[0] ? 16'h7fff : 16'h8000;
    return 16'((f * 16'h2b6d) + (s * 16'h0f35) + 16'h8001);
  endfunction

  task automatic run_frame(input int f, input bit acks, input int nbits);
    step(1'b0, 1'b1, acks);
    if (acks) pend_m = 1'b0;
    chk("R8 handshake low after frame pulse", ready_tgl, 0);
    chk("R8 holding kept over frame pulse", byte_out, last_byte);
    for (int n = 1; n <= nbits; n++) begin
      int s = (n - 1) / 16;
      int b = 15 - ((n - 1) % 16);
      logic [15:0] w = word_of(f, s);
      logic ack = acks && (n % 8 == 1);
      logic lat = (n % 8 == 0);
      step(w[b], 1'b0, ack);
      if (lat) begin
        if (pend_m && !ack) ovr_m = 1'b1;
        pend_m = 1'b1;
      end else if (ack) pend_m = 1'b0;
      chk("R3 handshake level", ready_tgl, (n % 16) >= 8);
      if (lat) begin
        last_byte = (n % 16 == 8) ? w[15:8] : w[7:0];
        chk("R2 latched byte", byte_out, last_byte);
        chk("R4 byte index", byte_hi, (n % 16 == 8));
        chk("R5 slot index", slot_idx, s);
        chk("R6 valid qualifier", byte_valid, s < 2);
        chk("R9 overrun flag", overrun, ovr_m);
      end else if (n % 8 == 4) begin
        chk("R10 holding stable", byte_out, last_byte);
      end
    end
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      step(i[0], 1'b0, 1'b0);
      chk("R7 no handshake while idle", ready_tgl, 0);
      chk("R7 no latch while idle", byte_out, last_byte);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge sclk);
    chk("R1 reset byte", byte_out, 0);
    chk("R1 reset handshake", ready_tgl, 0);
    chk("R1 reset qualifiers", {byte_hi, slot_idx, byte_valid, overrun}, 0);
    rst_n = 1'b1;
    idle(12);
    for (int f = 0; f < 4; f++) begin
      run_frame(f, 1'b1, 96);
      idle(5 + f);
    end
    run_frame(5, 1'b1, 12);
    run_frame(6, 1'b1, 96);
    chk("R9 no overrun with acks", overrun, 0);
    run_frame(7, 1'b0, 96);
    chk("R9 overrun after unacked bytes", overrun, 1);
    idle(4);
    run_frame(8, 1'b1, 40);
    chk("R9 overrun sticky", overrun, 1);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset byte", byte_out, 0);
    chk("R1 async reset flags", {ready_tgl, byte_hi, slot_idx, byte_valid, overrun}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule